// File: doc/BRIEF.md
# Cache-Line-Aware Burst Length Selector

This block sits beside the bus sequencer of a bus-master DMA engine. It plans how a long memory-to-memory or block transfer is cut into bursts. A transfer is opened with a start pulse that carries a word address and a word count. The block then presents one burst length at a time, each with a one-cycle valid strobe. It also reports whether that burst covers whole cache lines only, so that the sequencer may use a whole-line write command. After the sequencer signals that the burst has finished, the block advances its address, lowers its remaining count and plans the next burst. The block moves no data and drives no bus signals.

Bursts are planned against a cache line size, given in words on an 8-bit input, and a maximum burst code. While the address sits inside a line, the block first issues a short burst that stops at the next line boundary. Once aligned, it picks the largest whole number of lines that fits both the maximum burst and the remaining count. As the count runs down, the bursts shrink. A tail shorter than one line goes out as a single partial burst. A line size that is zero or not a power of two turns line planning off, and every burst is then one word long.

The control is a three-state machine. `ST_IDLE` moves to `ST_ISSUE` when a start arrives with a nonzero count. `ST_ISSUE` lasts one cycle, presents the burst and always moves to `ST_WAIT`. `ST_WAIT` holds until a burst-done pulse arrives. It then goes back to `ST_ISSUE` if words remain, or to `ST_IDLE` if that burst finished the transfer.

Top module: `burst_len_sel`

## Requirements
- R1: After reset, `busy`, `burst_valid` and `line_cmd` are 0 and `words_left` is 0.
- R2: In idle, a `start` with nonzero `start_count` raises `burst_valid` exactly one cycle later, with `words_left` equal to that count. A start with a zero count is ignored. A start while `busy` is 1 is ignored.
- R3: If `line_words` is 0 or not a power of two, every burst has length 1 and `line_cmd` is 0.
- R4: With a valid line size L, if the current word address modulo L is a nonzero value `off`, the burst length is min(L - off, remaining) and `line_cmd` is 0.
- R5: If the address is aligned to L and the remaining count is below L, the burst length equals the remaining count and `line_cmd` is 0.
- R6: If the address is aligned and the remaining count is at least L, the burst length is the largest multiple of L that does not exceed min(maximum burst, remaining). If that multiple would be 0, the length is L instead. `line_cmd` is 1.
- R7: `max_sel` codes 0 to 6 select a maximum burst of 2^(code+1) words (2 to 128). Code 7 selects 128.
- R8: A `burst_done` pulse in `ST_WAIT` lowers `words_left` by the burst length and advances the address by the same amount. The next burst is presented exactly one cycle later. If no words remain, `busy` falls one cycle later instead.
- R9: `burst_done` is ignored while idle and in the cycle when `burst_valid` is high.
- R10: `burst_valid` is high for a single cycle per burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Opens a transfer |
| start_addr | input | ADDR_W | Word address of the first word |
| start_count | input | CNT_W | Number of words to move |
| line_words | input | LINE_W | Cache line size in words |
| max_sel | input | SEL_W | Maximum burst code |
| burst_done | input | 1 | The presented burst has completed |
| burst_valid | output | 1 | Strobe: a new burst length is presented |
| burst_len | output | LEN_W | Burst length in words |
| line_cmd | output | 1 | The burst consists of whole, aligned cache lines |
| busy | output | 1 | A transfer is in progress |
| words_left | output | CNT_W | Words not yet covered by completed bursts |

## Verification
The bench goes after misaligned starts. A design that did not stop at the line boundary would overrun it and raise `line_cmd` on a partial line. It also covers the shrinking tail of an aligned transfer. Rounding the wrong way there would give a burst that is not a line multiple or that exceeds the remaining count. Line sizes that are not powers of two, or zero, check that no line burst is attempted. A maximum burst smaller than one line checks that one full line is still issued. A done pulse during the valid cycle and a start during a transfer check that they cannot double-count words or restart the transfer.

// File: rtl/burst_sel_pkg.sv
package burst_sel_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } bst_state_t;
endpackage

// File: rtl/bsel_line_check.sv
module bsel_line_check #(
    parameter int LINE_W = 8
) (
    input  logic [LINE_W-1:0] line_words,
    output logic              line_ok,
    output logic [LINE_W-1:0] line_mask
);
    always_comb begin
        line_mask = line_words - LINE_W'(1);
        line_ok   = (line_words != '0) && ((line_words & line_mask) == '0);
    end
endmodule

// File: rtl/bsel_max_decode.sv
module bsel_max_decode #(
    parameter int SEL_W = 3,
    parameter int LEN_W = 8
) (
    input  logic [SEL_W-1:0] max_sel,
    output logic [LEN_W-1:0] max_words
);
    localparam int TOP_CODE = LEN_W - 2;

    always_comb begin
        max_words = '0;
        for (int i = 0; i < (1 << SEL_W); i++) begin
            if (int'(max_sel) == i) begin
                if (i > TOP_CODE)
                    max_words = LEN_W'(1) << (TOP_CODE + 1);
                else
                    max_words = LEN_W'(1) << (i + 1);
            end
        end
    end
endmodule

// File: rtl/bsel_calc.sv
module bsel_calc #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int LINE_W = 8,
    parameter int LEN_W  = 8
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [CNT_W-1:0]  remaining,
    input  logic [LINE_W-1:0] line_words,
    input  logic              line_ok,
    input  logic [LINE_W-1:0] line_mask,
    input  logic [LEN_W-1:0]  max_words,
    output logic [LEN_W-1:0]  len,
    output logic              whole_lines
);
    logic [LINE_W-1:0] off;
    logic [LINE_W-1:0] to_bnd;
    logic [CNT_W-1:0]  line_ext;
    logic [CNT_W-1:0]  mask_ext;
    logic [CNT_W-1:0]  max_ext;
    logic [CNT_W-1:0]  cap;
    logic [CNT_W-1:0]  fit;
    logic [CNT_W-1:0]  pick;

    always_comb begin
        off      = cur_addr[LINE_W-1:0] & line_mask;
        to_bnd   = line_words - off;
        line_ext = CNT_W'(line_words);
        mask_ext = CNT_W'(line_mask);
        max_ext  = CNT_W'(max_words);
        cap      = (remaining < max_ext) ? remaining : max_ext;
        fit      = cap & ~mask_ext;
        whole_lines = 1'b0;
        if (!line_ok) begin
            pick = CNT_W'(1);
        end else if (off != '0) begin
            pick = (CNT_W'(to_bnd) < remaining) ? CNT_W'(to_bnd) : remaining;
        end else if (remaining < line_ext) begin
            pick = remaining;
        end else begin
            pick        = (fit == '0) ? line_ext : fit;
            whole_lines = 1'b1;
        end
        len = LEN_W'(pick);
    end
endmodule

// File: rtl/burst_len_sel.sv
module burst_len_sel
    import burst_sel_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int LINE_W = 8,
    parameter int SEL_W  = 3,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [CNT_W-1:0]  start_count,
    input  logic [LINE_W-1:0] line_words,
    input  logic [SEL_W-1:0]  max_sel,
    input  logic              burst_done,
    output logic              burst_valid,
    output logic [LEN_W-1:0]  burst_len,
    output logic              line_cmd,
    output logic              busy,
    output logic [CNT_W-1:0]  words_left
);
    bst_state_t        state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  rem_q;
    logic [LEN_W-1:0]  len_q;
    logic              cmd_q;

    logic              line_ok;
    logic [LINE_W-1:0] line_mask;
    logic [LEN_W-1:0]  max_words;
    logic [LEN_W-1:0]  calc_len;
    logic              calc_cmd;
    logic              take_start;
    logic              take_done;
    logic              last_burst;

    bsel_line_check #(.LINE_W(LINE_W)) u_line (
        .line_words (line_words),
        .line_ok    (line_ok),
        .line_mask  (line_mask)
    );

    bsel_max_decode #(.SEL_W(SEL_W), .LEN_W(LEN_W)) u_max (
        .max_sel   (max_sel),
        .max_words (max_words)
    );

    bsel_calc #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .LINE_W(LINE_W), .LEN_W(LEN_W)
    ) u_calc (
        .cur_addr    (addr_q),
        .remaining   (rem_q),
        .line_words  (line_words),
        .line_ok     (line_ok),
        .line_mask   (line_mask),
        .max_words   (max_words),
        .len         (calc_len),
        .whole_lines (calc_cmd)
    );

    assign take_start = (state_q == ST_IDLE) && start && (start_count != '0);
    assign take_done  = (state_q == ST_WAIT) && burst_done;
    assign last_burst = (rem_q == CNT_W'(len_q));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (take_start) state_d = ST_ISSUE;
            ST_ISSUE: state_d = ST_WAIT;
            ST_WAIT:  if (take_done) state_d = last_burst ? ST_IDLE : ST_ISSUE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            rem_q  <= '0;
            len_q  <= '0;
            cmd_q  <= 1'b0;
        end else if (take_start) begin
            addr_q <= start_addr;
            rem_q  <= start_count;
        end else if (state_q == ST_ISSUE) begin
            len_q <= calc_len;
            cmd_q <= calc_cmd;
        end else if (take_done) begin
            addr_q <= addr_q + ADDR_W'(len_q);
            rem_q  <= rem_q - CNT_W'(len_q);
        end
    end

    always_comb begin
        burst_valid = (state_q == ST_ISSUE);
        busy        = (state_q != ST_IDLE);
        words_left  = rem_q;
        burst_len   = burst_valid ? calc_len : len_q;
        line_cmd    = burst_valid ? calc_cmd : cmd_q;
    end
endmodule

// File: rtl/burst_len_sel_chk.sv
module burst_len_sel_chk #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int LINE_W = 8,
    parameter int SEL_W  = 3,
    parameter int LEN_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [CNT_W-1:0]  start_count,
    input logic [LINE_W-1:0] line_words,
    input logic [SEL_W-1:0]  max_sel,
    input logic              burst_done,
    input logic              burst_valid,
    input logic [LEN_W-1:0]  burst_len,
    input logic              line_cmd,
    input logic              busy,
    input logic [CNT_W-1:0]  words_left
);
    int lw, bl, wl, mw, lim;
    logic pow2;

    always_comb begin
        lw   = int'(line_words);
        bl   = int'(burst_len);
        wl   = int'(words_left);
        pow2 = (lw != 0) && ((lw & (lw - 1)) == 0);
        mw   = (int'(max_sel) > LEN_W - 2) ? (1 << (LEN_W - 1)) : (2 << int'(max_sel));
        lim  = (mw > lw) ? mw : lw;
    end

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        burst_valid |=> !burst_valid); // R10
    AST_START_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && start && start_count != '0 |=> burst_valid && words_left == $past(start_count)); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !(start && start_count != '0) |=> !busy); // R2
    AST_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
        burst_valid && !pow2 |-> bl == 1 && !line_cmd); // R3
    AST_LINE_MULT: assert property (@(posedge clk) disable iff (!rst_n)
        burst_valid && line_cmd |-> pow2 && (bl % lw) == 0 && bl >= lw); // R6
    AST_MAX_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        burst_valid && line_cmd |-> bl <= lim); // R7
    AST_LEN_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
        burst_valid |-> bl != 0 && bl <= wl); // R8
    AST_NEXT_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !burst_valid && burst_done && wl > bl |=> burst_valid && words_left == $past(words_left) - CNT_W'($past(burst_len))); // R8
    AST_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !burst_valid && burst_done && wl == bl |=> !busy && words_left == '0); // R8
    AST_DONE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        burst_valid |=> $stable(words_left) && busy); // R9
endmodule

bind burst_len_sel burst_len_sel_chk #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .LINE_W(LINE_W), .SEL_W(SEL_W), .LEN_W(LEN_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .start_count(start_count),
    .line_words(line_words), .max_sel(max_sel), .burst_done(burst_done),
    .burst_valid(burst_valid), .burst_len(burst_len), .line_cmd(line_cmd),
    .busy(busy), .words_left(words_left)
);

// File: tb/burst_len_sel_test.sv
module burst_len_sel_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] start_addr = '0;
    logic [15:0] start_count = '0;
    logic [7:0]  line_words = '0;
    logic [2:0]  max_sel = '0;
    logic        burst_done = 1'b0;
    logic        burst_valid;
    logic [7:0]  burst_len;
    logic        line_cmd;
    logic        busy;
    logic [15:0] words_left;

    int n_checks = 0;
    int n_fails = 0;
    bit finished = 0;
    int m_addr;
    int m_rem;

    burst_len_sel uut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .start_count(start_count), .line_words(line_words), .max_sel(max_sel),
        .burst_done(burst_done), .burst_valid(burst_valid), .burst_len(burst_len),
        .line_cmd(line_cmd), .busy(busy), .words_left(words_left)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Expected {flag, length} from the requirements.
    function automatic int model_len(input int a, input int rem, input int l, input int sel, output bit flag, output string req);
        int off, mw, fit, m;
        flag = 0;
        if (l == 0 || (l & (l - 1)) != 0) begin req = "R3"; return 1; end
        off = a & (l - 1);
        if (off != 0) begin req = "R4"; return (l - off < rem) ? l - off : rem; end
        if (rem < l) begin req = "R5"; return rem; end
        mw  = (sel > 6) ? 128 : (2 << sel);
        fit = (mw < rem) ? mw : rem;
        m   = (fit / l) * l;
        if (m == 0) m = l;
        flag = 1;
        req = (sel == 7) ? "R7" : "R6";
        return m;
    endfunction

    task automatic check_burst();
        bit ef;
        string rq;
        int el;
        el = model_len(m_addr, m_rem, int'(line_words), int'(max_sel), ef, rq);
        chk("R2/R8 valid", int'(burst_valid), 1);
        chk("R8 words_left", int'(words_left), m_rem);
        chk({rq, " len"}, int'(burst_len), el);
        chk({rq, " line_cmd"}, int'(line_cmd), int'(ef));
    endtask

    task automatic begin_xfer(input int a, input int cnt, input int l, input int sel);
        @(negedge clk);
        start = 1'b1; start_addr = a; start_count = 16'(cnt);
        line_words = 8'(l); max_sel = 3'(sel);
        @(negedge clk);
        start = 1'b0;
        m_addr = a; m_rem = cnt;
    endtask

    task automatic done_pulse();
        repeat ($urandom % 3) begin
            @(negedge clk);
            chk("R10 single pulse", int'(burst_valid), 0);
        end
        burst_done = 1'b1;
        @(negedge clk);
        burst_done = 1'b0;
    endtask

    task automatic drain();
        int l;
        while (m_rem > 0) begin
            check_burst();
            l = int'(burst_len);
            @(negedge clk);
            chk("R10 single pulse", int'(burst_valid), 0);
            done_pulse();
            m_addr += l; m_rem -= l;
        end
        chk("R8 busy drops", int'(busy), 0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 busy", int'(busy), 0);
        chk("R1 valid", int'(burst_valid), 0);
        chk("R1 line_cmd", int'(line_cmd), 0);
        chk("R1 words_left", int'(words_left), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 zero count ignored
        start = 1'b1; start_count = 16'd0; line_words = 8'd16;
        @(negedge clk);
        start = 1'b0;
        chk("R2 zero count", int'(busy), 0);
        @(negedge clk);
        chk("R2 zero count no valid", int'(burst_valid), 0);

        // R9 done while idle
        burst_done = 1'b1;
        @(negedge clk);
        burst_done = 1'b0;
        chk("R9 idle done", int'(busy), 0);
        chk("R9 idle done words", int'(words_left), 0);

        // R6 R7 aligned step-down
        begin_xfer(0, 184, 16, 5); drain();
        // R4 R7 misaligned start, code 7
        begin_xfer(5, 300, 32, 7); drain();
        // R5 short tail below one line
        begin_xfer(64, 10, 64, 3); drain();
        // R3 invalid line sizes
        begin_xfer(7, 5, 12, 4); drain();
        begin_xfer(0, 3, 0, 6); drain();
        // R6 maximum smaller than a line
        begin_xfer(0, 24, 8, 1); drain();

        // R9 done in valid cycle, R2 start while busy
        begin_xfer(0, 64, 8, 2);
        check_burst();
        burst_done = 1'b1; start = 1'b1; start_count = 16'd999; start_addr = 32'd3;
        @(negedge clk);
        burst_done = 1'b0; start = 1'b0;
        chk("R9 done during valid", int'(words_left), 64);
        chk("R9 still busy", int'(busy), 1);
        chk("R2 busy start ignored", int'(burst_valid), 0);
        done_pulse();
        m_addr += 8; m_rem -= 8;
        drain();

        // constrained random transfers
        for (int t = 0; t < 30; t++) begin
            int l;
            case ($urandom % 12)
                0: l = 0;   1: l = 1;   2: l = 2;   3: l = 4;
                4: l = 8;   5: l = 16;  6: l = 32;  7: l = 64;
                8: l = 128; 9: l = 3;   10: l = 12; default: l = 255;
            endcase
            begin_xfer(int'($urandom), 1 + int'($urandom % 300), l, int'($urandom % 8));
            drain();
        end
        finish_run();
    end
endmodule